// File: doc/BRIEF.md
# Branch Resolution and Fetch Control

This block owns the program counter of a five-stage in-order pipeline, together with the register that carries a fetched instruction from the fetch stage into decode. Each cycle it presents the fetch address to an external instruction memory and captures the returned word alongside the address it came from. When the decode stage reports a conditional branch, the block compares the two register operands for equality. It forms the target by adding a sign-extended word offset, scaled by four, to the branch's own address. If the branch is taken, the block steers the next fetch to that target.

The treatment of the instruction fetched right behind a branch is fixed at build time by the `POLICY` parameter. `SUCC_REFETCH` (0) discards that instruction after every branch. `SUCC_PREDICT_NT` (1) discards it only when the branch is taken. `SUCC_DELAYED` (2) always keeps it as a delay slot. `SUCC_LIKELY` (3) keeps it as a delay slot but drops it when a branch flagged as "likely" falls through. A discarded instruction stays in decode as a bubble: its register-write and memory-write enables are forced low and, if it is itself a branch, it is never evaluated. A hazard stall from elsewhere freezes the PC and the decode register, and it suppresses branch evaluation.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the fetch address is `RESET_PC` and decode holds a bubble (`id_valid_o` low, `id_pc_o` and `id_instr_o` zero).
- R2: On a cycle with `stall_i` low and no redirect, the fetch address advances by 4 on the next cycle, and decode takes the previous fetch address and the word read there.
- R3: On a cycle with `stall_i` high, the fetch address, the decode address, the decode instruction and its bubble state all stay unchanged on the next cycle, and no redirect is raised.
- R4: A live branch is taken when `id_opnd_a_i == id_opnd_b_i`. Its target is `id_pc_o + (sign_extend(id_offset_i) << 2)`. When it is taken, `redirect_o` is high in that decode cycle and the fetch address equals the target on the next cycle.
- R5: With POLICY=0, every live branch redirects. The fetch resumes at the target if the branch is taken, or at the branch address plus 4 if it is not, and the instruction that enters decode next is a bubble.
- R6: With POLICY=1, the successor of a taken branch becomes a bubble, while the successor of a not-taken branch proceeds and fetch carries on sequentially.
- R7: With POLICY=2, the successor of a branch always proceeds as a valid instruction, whether the branch is taken or not.
- R8: With POLICY=3, a branch with `id_is_likely_i` high that is not taken turns its successor into a bubble. A taken branch, or any branch with `id_is_likely_i` low, keeps its successor valid.
- R9: While decode holds a bubble, `id_reg_we_o` and `id_mem_we_o` are low and a branch indication in decode is ignored: no redirect, and fetch advances by 4. Otherwise the two enables follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hazard stall: freeze fetch and decode |
| imem_addr_o | output | XLEN | Fetch address to instruction memory |
| imem_rdata_i | input | ILEN | Instruction word read at `imem_addr_o` |
| id_instr_o | output | ILEN | Instruction held in decode |
| id_pc_o | output | XLEN | Address of the instruction in decode |
| id_valid_o | output | 1 | Low when decode holds a bubble |
| id_is_branch_i | input | 1 | Decoded: instruction in decode is a conditional branch |
| id_is_likely_i | input | 1 | Decoded: the branch is of the likely kind |
| id_opnd_a_i | input | XLEN | First register operand for the compare |
| id_opnd_b_i | input | XLEN | Second register operand for the compare |
| id_offset_i | input | OFF_W | Signed word offset of the branch |
| id_reg_we_i | input | 1 | Decoded register-write enable |
| id_mem_we_i | input | 1 | Decoded memory-write enable |
| id_reg_we_o | output | 1 | Register-write enable after squashing |
| id_mem_we_o | output | 1 | Memory-write enable after squashing |
| redirect_o | output | 1 | The fetch address is being replaced this cycle |

## Verification
The assertions assume that every input carries a known value on each clock edge after reset. They also assume that the decode-side branch flags, operands and offset describe the instruction currently in decode. Beyond that, they place no limit on how long a stall lasts or on how often branches arrive. The stimulus drives known values on every cycle and changes them only at the falling clock edge. The branch flags are drawn independently of the instruction word, so branches land in delay slots, on bubbles and under stalls, and every one of those cases stays legal for the checks.

// File: rtl/brfc_pkg.sv
package brfc_pkg;
  typedef enum logic [1:0] {
    SUCC_REFETCH    = 2'd0,
    SUCC_PREDICT_NT = 2'd1,
    SUCC_DELAYED    = 2'd2,
    SUCC_LIKELY     = 2'd3
  } succ_policy_e;
endpackage

// File: rtl/brfc_pc_reg.sv
module brfc_pc_reg #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              STEP     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            redirect,
  input  logic [XLEN-1:0] dest,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] INC = XLEN'(STEP);

  always_ff @(posedge clk) begin
    if (rst)           pc <= RESET_PC;
    else if (!hold) begin
      if (redirect)    pc <= dest;
      else             pc <= pc + INC;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(hold) && !$past(redirect)) |-> (pc == $past(pc) + INC));

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hold)) |-> $stable(pc));

  p_pc_redirect_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(hold) && $past(redirect)) |-> (pc == $past(dest)));
endmodule

// File: rtl/brfc_ifid.sv
module brfc_ifid #(
  parameter int XLEN = 32,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [XLEN-1:0] pc_in,
  input  logic [ILEN-1:0] instr_in,
  input  logic            kill_in,
  output logic [XLEN-1:0] id_pc,
  output logic [ILEN-1:0] id_instr,
  output logic            id_kill
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_pc    <= '0;
      id_instr <= '0;
      id_kill  <= 1'b1;
    end else if (!hold) begin
      id_pc    <= pc_in;
      id_instr <= instr_in;
      id_kill  <= kill_in;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_ifid_reset_bubble_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> id_kill);

  p_ifid_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hold)) |-> ($stable(id_pc) && $stable(id_instr) && $stable(id_kill)));
endmodule

// File: rtl/brfc_resolve.sv
module brfc_resolve
  import brfc_pkg::*;
#(
  parameter int           XLEN   = 32,
  parameter int           OFF_W  = 16,
  parameter succ_policy_e POLICY = SUCC_PREDICT_NT
) (
  input  logic             is_branch,
  input  logic             is_likely,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0]  id_pc,
  input  logic             live,
  output logic             redirect,
  output logic [XLEN-1:0]  dest,
  output logic             kill_next
);
  localparam int              EXT_W = XLEN - OFF_W - 2;
  localparam logic [XLEN-1:0] WORD  = XLEN'(4);

  logic            equal, evaluated, taken;
  logic [XLEN-1:0] off_ext, target, fallthru;

  assign equal     = (opnd_a == opnd_b);
  assign evaluated = is_branch && live;
  assign taken     = evaluated && equal;
  assign off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign target    = id_pc + off_ext;
  assign fallthru  = id_pc + WORD;

  always_comb begin
    redirect  = taken;
    dest      = target;
    kill_next = 1'b0;
    unique case (POLICY)
      SUCC_REFETCH: begin
        redirect  = evaluated;
        dest      = taken ? target : fallthru;
        kill_next = evaluated;
      end
      SUCC_PREDICT_NT: kill_next = taken;
      SUCC_DELAYED:    kill_next = 1'b0;
      SUCC_LIKELY:     kill_next = evaluated && is_likely && !equal;
      default:         kill_next = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
  import brfc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              ILEN     = 32,
  parameter int              OFF_W    = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter succ_policy_e    POLICY   = SUCC_PREDICT_NT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall_i,
  output logic [XLEN-1:0]  imem_addr_o,
  input  logic [ILEN-1:0]  imem_rdata_i,
  output logic [ILEN-1:0]  id_instr_o,
  output logic [XLEN-1:0]  id_pc_o,
  output logic             id_valid_o,
  input  logic             id_is_branch_i,
  input  logic             id_is_likely_i,
  input  logic [XLEN-1:0]  id_opnd_a_i,
  input  logic [XLEN-1:0]  id_opnd_b_i,
  input  logic [OFF_W-1:0] id_offset_i,
  input  logic             id_reg_we_i,
  input  logic             id_mem_we_i,
  output logic             id_reg_we_o,
  output logic             id_mem_we_o,
  output logic             redirect_o
);
  localparam int STEP = 4;

  logic [XLEN-1:0] pc, dest;
  logic            redirect, kill_next, id_kill, live;

  assign live = !id_kill && !stall_i;

  brfc_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(STEP)) u_pc (
    .clk(clk), .rst(rst), .hold(stall_i),
    .redirect(redirect), .dest(dest), .pc(pc)
  );

  brfc_resolve #(.XLEN(XLEN), .OFF_W(OFF_W), .POLICY(POLICY)) u_resolve (
    .is_branch(id_is_branch_i), .is_likely(id_is_likely_i),
    .opnd_a(id_opnd_a_i), .opnd_b(id_opnd_b_i), .offset(id_offset_i),
    .id_pc(id_pc_o), .live(live),
    .redirect(redirect), .dest(dest), .kill_next(kill_next)
  );

  brfc_ifid #(.XLEN(XLEN), .ILEN(ILEN)) u_ifid (
    .clk(clk), .rst(rst), .hold(stall_i),
    .pc_in(pc), .instr_in(imem_rdata_i), .kill_in(kill_next),
    .id_pc(id_pc_o), .id_instr(id_instr_o), .id_kill(id_kill)
  );

  assign imem_addr_o = pc;
  assign id_valid_o  = !id_kill;
  assign id_reg_we_o = id_reg_we_i && !id_kill;
  assign id_mem_we_o = id_mem_we_i && !id_kill;
  assign redirect_o  = redirect;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_no_redirect_in_stall_r3: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !redirect_o);

  generate
    if (POLICY == SUCC_REFETCH) begin : g_chk_refetch
      p_refetch_bubble_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && id_is_branch_i)) |-> !id_valid_o);
    end else if (POLICY == SUCC_PREDICT_NT) begin : g_chk_nt
      p_nt_squash_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && redirect_o)) |-> !id_valid_o);
      p_nt_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && id_is_branch_i && (id_opnd_a_i != id_opnd_b_i)))
          |-> id_valid_o);
    end else if (POLICY == SUCC_DELAYED) begin : g_chk_delay
      p_delay_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && id_is_branch_i)) |-> id_valid_o);
    end else begin : g_chk_likely
      p_likely_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && redirect_o)) |-> id_valid_o);
      p_likely_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(live && id_is_branch_i && id_is_likely_i &&
                          (id_opnd_a_i != id_opnd_b_i))) |-> !id_valid_o);
    end
  endgenerate
endmodule

// File: tb/branch_fetch_ctrl_tb.sv
module branch_fetch_ctrl_tb;
  import brfc_pkg::*;

  localparam int          XLEN   = 32;
  localparam int          ILEN   = 32;
  localparam int          OFF_W  = 8;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam int          NCYC   = 6000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1, stall = 1'b0, br = 1'b0, lk = 1'b0, rwe = 1'b0, mwe = 1'b0;
  logic [XLEN-1:0]  opa = '0, opb = '0;
  logic [OFF_W-1:0] off = '0;

  logic [3:0][XLEN-1:0] o_pc, o_idpc;
  logic [3:0][ILEN-1:0] o_instr, rdata;
  logic [3:0]           o_valid, o_rwe, o_mwe, o_red;

  for (genvar g = 0; g < 4; g++) begin : g_pol
    assign rdata[g] = ~o_pc[g];
    branch_fetch_ctrl #(.XLEN(XLEN), .ILEN(ILEN), .OFF_W(OFF_W), .RESET_PC(RST_PC),
                        .POLICY(succ_policy_e'(g))) u_dut (
      .clk(clk), .rst(rst), .stall_i(stall),
      .imem_addr_o(o_pc[g]), .imem_rdata_i(rdata[g]),
      .id_instr_o(o_instr[g]), .id_pc_o(o_idpc[g]), .id_valid_o(o_valid[g]),
      .id_is_branch_i(br), .id_is_likely_i(lk),
      .id_opnd_a_i(opa), .id_opnd_b_i(opb), .id_offset_i(off),
      .id_reg_we_i(rwe), .id_mem_we_i(mwe),
      .id_reg_we_o(o_rwe[g]), .id_mem_we_o(o_mwe[g]), .redirect_o(o_red[g])
    );
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [XLEN-1:0] m_pc[4], m_idpc[4];
  logic [ILEN-1:0] m_instr[4];
  logic            m_kill[4];
  string           t_pc[4], t_valid[4];

  task automatic chk(input bit ok, input string tag, input string what, input int p,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s policy%0d %s actual=%h expected=%h", tag, p, what, act, exp);
    end
  endtask

  // Expected outcome of decode for policy p with the given inputs (R4..R8 encodings).
  task automatic resolve(input int p, input logic s, output logic red,
                         output logic [31:0] dst, output logic kn);
    logic ev, eq, tk;
    logic [31:0] tgt;
    eq  = (opa == opb);
    ev  = br && !m_kill[p] && !s;
    tk  = ev && eq;
    tgt = m_idpc[p] + ({{(32-OFF_W){off[OFF_W-1]}}, off} << 2);
    dst = tgt; red = tk; kn = 1'b0;
    case (p)
      0: begin red = ev; dst = tk ? tgt : m_idpc[p] + 32'd4; kn = ev; end
      1: kn = tk;
      2: kn = 1'b0;
      default: kn = ev && lk && !eq;
    endcase
  endtask

  function automatic string pol_tag(input int p);
    case (p)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic advance();
    logic red, kn;
    logic [31:0] dst;
    for (int p = 0; p < 4; p++) begin
      if (rst) begin
        m_pc[p] = RST_PC; m_idpc[p] = '0; m_instr[p] = '0; m_kill[p] = 1'b1;
        t_pc[p] = "R1"; t_valid[p] = "R1";
      end else if (stall) begin
        t_pc[p] = "R3"; t_valid[p] = "R3";
      end else begin
        resolve(p, 1'b0, red, dst, kn);
        t_pc[p]    = red ? "R4" : (br && m_kill[p]) ? "R9" : "R2";
        t_valid[p] = (br && !m_kill[p]) ? pol_tag(p) : "R2";
        m_idpc[p]  = m_pc[p];
        m_instr[p] = ~m_pc[p];
        m_kill[p]  = kn;
        m_pc[p]    = red ? dst : m_pc[p] + 32'd4;
      end
    end
  endtask

  task automatic compare();
    logic red, kn;
    logic [31:0] dst;
    for (int p = 0; p < 4; p++) begin
      resolve(p, stall, red, dst, kn);
      chk(o_pc[p] == m_pc[p], t_pc[p], "fetch address", p, o_pc[p], m_pc[p]);
      chk(o_idpc[p] == m_idpc[p], t_pc[p] == "R1" ? "R1" : "R2", "decode pc", p, o_idpc[p], m_idpc[p]);
      chk(o_instr[p] == m_instr[p], t_pc[p] == "R3" ? "R3" : "R2", "decode instr", p, o_instr[p], m_instr[p]);
      chk(o_valid[p] == !m_kill[p], t_valid[p], "decode valid", p, 32'(o_valid[p]), 32'(!m_kill[p]));
      chk(o_rwe[p] == (rwe && !m_kill[p]), "R9", "reg write enable", p, 32'(o_rwe[p]), 32'(rwe && !m_kill[p]));
      chk(o_mwe[p] == (mwe && !m_kill[p]), "R9", "mem write enable", p, 32'(o_mwe[p]), 32'(mwe && !m_kill[p]));
      chk(o_red[p] == (red && !rst), stall ? "R3" : "R4", "redirect", p, 32'(o_red[p]), 32'(red && !rst));
    end
  endtask

  initial begin
    logic [31:0] r;
    r = 32'h1234_5678;
    @(negedge clk);
    advance();
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      compare();
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      rst   = (c < 2) || (c >= 3000 && c < 3002);
      stall = (r[2:0] == 3'd0);
      br    = r[4] | r[22];
      lk    = r[5];
      rwe   = r[20];
      mwe   = r[21];
      off   = r[19:12];
      opa   = {16'h0, r[31:24], r[7:0]};
      opb   = r[6] ? opa : opa ^ (32'd1 << r[11:7]);
      advance();
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule